// File: doc/BRIEF.md
# Dual-Output Prioritized Interrupt Controller

This block gathers thirty-two interrupt inputs and turns them into two processor request lines: a normal request (`irq_o`) and a fast request (`fiq_o`). Every input first passes through a per-input polarity stage and an optional capture latch. The result then feeds two banks with the same layout. Each bank keeps its own enable mask, its own priority ceiling and its own latched state. The two banks share the polarity choice, the latch choice and a 4-bit priority for each input.

Software reaches all state through a simple 32-bit register bus. The byte-address layout is listed in the requirements; register reads return their data one cycle after the read strobe. A handler reads the current-source register of its bank to learn which input won arbitration. It reads the acknowledge register of the same bank to clear that bank's captured inputs. It keeps going until the masked status reads zero.

Top module: `dual_intc`

## Requirements
- R1: The polarity register at address 0x200 has one bit per input (bit n for input n). It resets to all ones. A 1 uses the input as driven and a 0 uses its complement.
- R2: The capture register at address 0x204 resets to zero. An input whose bit is 0 is level-sensitive. An input whose bit is 1 stays pending in each bank, after its conditioned level drops, until that bank is acknowledged.
- R3: Each bank has an enable-set register at bank base + 0x08. Writing 1 bits sets those mask bits and writing 0 bits changes nothing. Reading base + 0x08 or base + 0x0C returns the mask, which resets to zero.
- R4: Each bank has an enable-clear register at bank base + 0x0C. Writing 1 bits clears those mask bits and writing 0 bits changes nothing.
- R5: Raw status at bank base + 0x04 shows every conditioned pending input whether or not it is enabled. Masked status at base + 0x00 is raw status AND the bank mask, and does not depend on the ceiling.
- R6: The priority of input n sits in bits [3:0] of the word at 0x300 + 4n and resets to 0. The bank ceiling sits in bits [3:0] at base + 0x2C and resets to 0xF. An enabled pending input qualifies in a bank only if its priority is less than or equal to that ceiling.
- R7: Current source at base + 0x20 returns the index of the qualifying input with the smallest priority value. Equal values go to the lower index. The register returns 32 when no input qualifies.
- R8: A read of base + 0x28 returns 0 and clears the captured inputs of that bank only.
- R9: The bank at base 0x000 drives `irq_o` and the bank at base 0x100 drives `fiq_o`. Each output is registered and goes high one clock after any input qualifies in its bank.
- R10: Read data is registered and holds between reads. An unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Interrupt inputs, bit n is input n |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, with side effects on the acknowledge register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A table of input patterns is applied with a fixed priority set-up. The patterns are:
- a single pending input;
- two inputs with different priorities;
- two inputs with equal priorities;
- enabled and disabled inputs mixed;
- only disabled inputs.

Each pattern checks both the normal request and the current-source number, so each one separates a correct tie rule, masking or priority comparison from a faulty one. Directed tests then run:
- the ceiling with an input above and below it;
- an inverted input;
- a one-cycle pulse on a captured input, acknowledged in one bank and then the other, which shows that the acknowledge of one bank leaves the other bank's captured state intact.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NSRC_DEF = 32;
    localparam int PRIO_W_DEF = 4;
    localparam int ADDR_W_DEF = 12;
    localparam int DATA_W = 32;

    localparam logic [7:0] OFF_MASKED = 8'h00;
    localparam logic [7:0] OFF_RAW    = 8'h04;
    localparam logic [7:0] OFF_ENSET  = 8'h08;
    localparam logic [7:0] OFF_ENCLR  = 8'h0C;
    localparam logic [7:0] OFF_CUR    = 8'h20;
    localparam logic [7:0] OFF_ACK    = 8'h28;
    localparam logic [7:0] OFF_CEIL   = 8'h2C;
endpackage

// File: rtl/intc_bank.sv
module intc_bank #(
    parameter int NSRC = 32,
    parameter int PW = 4,
    localparam int IW = $clog2(NSRC) + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSRC-1:0]        cond,
    input  logic [NSRC-1:0]        capture,
    input  logic [NSRC-1:0][PW-1:0] prio,
    input  logic                   set_we,
    input  logic                   clr_we,
    input  logic                   ceil_we,
    input  logic [NSRC-1:0]        wdata,
    input  logic                   ack,
    output logic [NSRC-1:0]        raw,
    output logic [NSRC-1:0]        masked,
    output logic [NSRC-1:0]        mask,
    output logic [PW-1:0]          ceil,
    output logic [IW-1:0]          cur,
    output logic                   req
);
    typedef struct packed {
        logic [NSRC-1:0] mask;
        logic [NSRC-1:0] held;
        logic [PW-1:0]   ceil;
        logic            req;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [NSRC-1:0] qual;
    logic [PW-1:0]   best_p;
    logic            found;

    always_comb begin
        st_d   = st_q;
        raw    = cond | st_q.held;
        masked = raw & st_q.mask;
        for (int n = 0; n < NSRC; n++)
            qual[n] = masked[n] && (prio[n] <= st_q.ceil);

        cur    = IW'(NSRC);
        best_p = '1;
        found  = 1'b0;
        for (int n = 0; n < NSRC; n++) begin
            if (qual[n] && (!found || prio[n] < best_p)) begin
                found  = 1'b1;
                best_p = prio[n];
                cur    = IW'(n);
            end
        end

        if (set_we)  st_d.mask = st_q.mask | wdata;
        if (clr_we)  st_d.mask = st_q.mask & ~wdata;
        if (ceil_we) st_d.ceil = wdata[PW-1:0];
        st_d.held = ((ack ? '0 : st_q.held) | cond) & capture;
        st_d.req  = |qual;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mask <= '0;
            st_q.held <= '0;
            st_q.ceil <= '1;
            st_q.req  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask = st_q.mask;
    assign ceil = st_q.ceil;
    assign req  = st_q.req;

    // R3: set bits become visible, others untouched
    a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && !clr_we) |=> ((st_q.mask & $past(wdata)) == $past(wdata)));
    // R4: cleared bits drop
    a_r4_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we) |=> ((st_q.mask & $past(wdata)) == '0));
    // R8: after an acknowledge only inputs asserted in that cycle stay captured
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> ((st_q.held & ~$past(cond)) == '0));
    // R9: a request needs an enabled pending input one cycle earlier
    a_r9_req_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> $past(|masked));
endmodule

// File: rtl/dual_intc.sv
module dual_intc #(
    parameter int NSRC = intc_pkg::NSRC_DEF,
    parameter int PW = intc_pkg::PRIO_W_DEF,
    parameter int AW = intc_pkg::ADDR_W_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          irq_o,
    output logic          fiq_o
);
    import intc_pkg::*;
    localparam int NBANK = 2;
    localparam int IW = $clog2(NSRC) + 1;

    typedef struct packed {
        logic [NSRC-1:0]         pol;
        logic [NSRC-1:0]         capture;
        logic [NSRC-1:0][PW-1:0] prio;
        logic [31:0]             rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [3:0] region;
    logic [7:0] off;
    logic [5:0] pidx;
    logic [NSRC-1:0] cond;
    logic [NSRC-1:0] raw    [NBANK];
    logic [NSRC-1:0] masked [NBANK];
    logic [NSRC-1:0] mask   [NBANK];
    logic [PW-1:0]   ceil   [NBANK];
    logic [IW-1:0]   cur    [NBANK];
    logic [NBANK-1:0] req;
    logic [NBANK-1:0] b_set, b_clr, b_ceil, b_ack;

    assign region = bus_addr[11:8];
    assign off    = bus_addr[7:0];
    assign pidx   = bus_addr[7:2];
    assign cond   = src_i ^ ~st_q.pol;

    generate
        for (genvar g = 0; g < NBANK; g++) begin : g_bank
            assign b_set[g]  = bus_wr && region == 4'(g) && off == OFF_ENSET;
            assign b_clr[g]  = bus_wr && region == 4'(g) && off == OFF_ENCLR;
            assign b_ceil[g] = bus_wr && region == 4'(g) && off == OFF_CEIL;
            assign b_ack[g]  = bus_rd && region == 4'(g) && off == OFF_ACK;

            intc_bank #(.NSRC(NSRC), .PW(PW)) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .cond    (cond),
                .capture (st_q.capture),
                .prio    (st_q.prio),
                .set_we  (b_set[g]),
                .clr_we  (b_clr[g]),
                .ceil_we (b_ceil[g]),
                .wdata   (bus_wdata[NSRC-1:0]),
                .ack     (b_ack[g]),
                .raw     (raw[g]),
                .masked  (masked[g]),
                .mask    (mask[g]),
                .ceil    (ceil[g]),
                .cur     (cur[g]),
                .req     (req[g])
            );
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            if (bus_addr == 12'h200) st_d.pol = bus_wdata[NSRC-1:0];
            if (bus_addr == 12'h204) st_d.capture = bus_wdata[NSRC-1:0];
            if (region == 4'h3 && int'(pidx) < NSRC && off[1:0] == 2'b00)
                st_d.prio[pidx] = bus_wdata[PW-1:0];
        end
        if (bus_rd) begin
            st_d.rdata = '0;
            if (region == 4'h0 || region == 4'h1) begin
                case (off)
                    OFF_MASKED:         st_d.rdata = 32'(masked[region[0]]);
                    OFF_RAW:            st_d.rdata = 32'(raw[region[0]]);
                    OFF_ENSET, OFF_ENCLR: st_d.rdata = 32'(mask[region[0]]);
                    OFF_CUR:            st_d.rdata = 32'(cur[region[0]]);
                    OFF_CEIL:           st_d.rdata = 32'(ceil[region[0]]);
                    default:            st_d.rdata = '0;
                endcase
            end else if (bus_addr == 12'h200) begin
                st_d.rdata = 32'(st_q.pol);
            end else if (bus_addr == 12'h204) begin
                st_d.rdata = 32'(st_q.capture);
            end else if (region == 4'h3 && int'(pidx) < NSRC && off[1:0] == 2'b00) begin
                st_d.rdata = 32'(st_q.prio[pidx]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pol     <= '1;
            st_q.capture <= '0;
            st_q.prio    <= '0;
            st_q.rdata   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign irq_o     = req[0];
    assign fiq_o     = req[1];

    // R1: a polarity write lands in the register
    a_r1_pol_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 12'h200) |=> (st_q.pol == $past(bus_wdata[NSRC-1:0])));
    // R10: read data holds while no read is issued
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd && !$past(!rst_n)) |=> $stable(bus_rdata));
endmodule

// File: tb/dual_intc_tb.sv
`timescale 1ns/1ps
module dual_intc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_intc u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    // {inputs, expected irq_o, expected current source}
    localparam logic [38:0] VEC [8] = '{
        {32'h0000_0000, 1'b0, 6'd32},
        {32'h0000_0002, 1'b1, 6'd1},
        {32'h0000_0006, 1'b1, 6'd2},
        {32'h0000_000C, 1'b1, 6'd2},
        {32'h0000_00A0, 1'b1, 6'd5},
        {32'h0000_0011, 1'b0, 6'd32},
        {32'h0000_008E, 1'b1, 6'd7},
        {32'hFFFF_0000, 1'b0, 6'd32}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic drive(input logic [31:0] v);
        @(negedge clk);
        src_i = v;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check("R9 irq_o after reset", 32'(irq_o), 0);
        check("R9 fiq_o after reset", 32'(fiq_o), 0);
        rd(12'h008, d); check("R3 mask reset", d, 0);
        rd(12'h12C, d); check("R6 ceiling reset", d, 32'hF);
        rd(12'h200, d); check("R1 polarity reset", d, 32'hFFFF_FFFF);
        rd(12'h204, d); check("R2 capture reset", d, 0);

        // set-up for the vector table
        wr(12'h008, 32'h0000_00AE);
        wr(12'h304, 5); wr(12'h308, 3); wr(12'h30C, 3);
        wr(12'h314, 1); wr(12'h31C, 1);
        rd(12'h314, d); check("R6 priority readback", d, 1);

        foreach (VEC[i]) begin
            drive(VEC[i][38:7]);
            check("R9 irq_o vector", 32'(irq_o), 32'(VEC[i][6]));
            check("R9 fiq_o idle vector", 32'(fiq_o), 0);
            rd(12'h020, d);
            check("R7 current source vector", d, 32'(VEC[i][5:0]));
        end

        // R5 raw vs masked
        drive(32'h0000_0011);
        rd(12'h004, d); check("R5 raw status", d, 32'h11);
        rd(12'h000, d); check("R5 masked status", d, 0);

        // R6 ceiling
        wr(12'h02C, 2);
        drive(32'h0000_0002);
        check("R6 above ceiling no irq", 32'(irq_o), 0);
        rd(12'h020, d); check("R6 above ceiling current", d, 32);
        rd(12'h000, d); check("R5 masked ignores ceiling", d, 32'h2);
        drive(32'h0000_0022);
        check("R6 below ceiling irq", 32'(irq_o), 1);
        rd(12'h020, d); check("R6 below ceiling current", d, 5);
        wr(12'h02C, 32'hF);

        // R3 / R4 enable set and clear
        drive(32'h0);
        wr(12'h00C, 32'h2);
        wr(12'h008, 32'h0);
        rd(12'h008, d); check("R4 clear one bit / R3 zero write", d, 32'hAC);
        wr(12'h00C, 32'h0);
        rd(12'h00C, d); check("R4 zero write no effect", d, 32'hAC);

        // R1 polarity, fast bank
        wr(12'h108, 32'h1);
        wr(12'h200, 32'hFFFF_FFFE);
        drive(32'h0);
        check("R1 inverted idle input raises fiq_o", 32'(fiq_o), 1);
        check("R9 irq_o independent of fast bank", 32'(irq_o), 0);
        rd(12'h120, d); check("R7 fast bank current", d, 0);
        drive(32'h1);
        check("R1 inverted active input drops fiq_o", 32'(fiq_o), 0);
        wr(12'h200, 32'hFFFF_FFFF);
        drive(32'h0);
        check("R1 restored polarity", 32'(fiq_o), 0);

        // R2 / R8 capture and per-bank acknowledge
        wr(12'h204, 32'h10);
        wr(12'h108, 32'h10);
        @(negedge clk); src_i = 32'h10;
        @(negedge clk); src_i = 32'h0;
        @(negedge clk);
        check("R2 captured input holds fiq_o", 32'(fiq_o), 1);
        rd(12'h004, d); check("R2 captured in normal bank", d, 32'h10);
        rd(12'h128, d); check("R8 acknowledge reads zero", d, 0);
        @(negedge clk);
        check("R8 fiq_o drops after acknowledge", 32'(fiq_o), 0);
        rd(12'h104, d); check("R8 fast bank raw cleared", d, 0);
        rd(12'h004, d); check("R8 other bank keeps capture", d, 32'h10);
        rd(12'h028, d);
        rd(12'h004, d); check("R8 normal bank cleared", d, 0);

        // R2 level-sensitive input does not hold
        wr(12'h204, 32'h0);
        @(negedge clk); src_i = 32'h10;
        @(negedge clk); src_i = 32'h0;
        @(negedge clk);
        check("R2 level input no hold", 32'(fiq_o), 0);

        // R10 unmapped and hold
        rd(12'h380, d); check("R10 unmapped reads zero", d, 0);
        @(negedge clk);
        check("R10 read data holds", bus_rdata, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule